// File: doc/BRIEF.md
# Optical-Black Level Averager and Clamp

This block removes the dark offset from digitised linear-sensor samples. Three colour channels (red, green, blue) arrive in parallel, one sample per channel per cycle. Each sample carries a region tag from the line timing generator. While a line is read out, the block sums the samples tagged as optical black. When the line ends, it divides that sum by the window size to get a rounded black level for each channel.

On the next line, the block subtracts that level from every sample tagged as active image data. Results below zero are clamped to zero. Only active samples reach the output, each one cycle after it enters. Idle, dummy and black samples are dropped.

The black window covers 42 pixel positions. In high-resolution mode, main and sub samples are interleaved, so the window delivers twice as many samples. In half-resolution mode it delivers one sample per position. The level is left unchanged on any line whose black window is not complete. After reset the level is zero until the first complete window has been seen.

Top module: `obc_black_clamp`

## Requirements
- R1: While reset is high and on the cycle after it, `out_vld` is low and the outputs are zero. All three black levels are cleared to zero, so the first line's active samples come out unchanged.
- R2: An output is produced only for a sample with `samp_vld` high and `samp_tag` = 2'b10 (active). `out_vld` is high on the cycle after such a sample. Samples tagged 2'b00 (idle), 2'b01 (black) or 2'b11 (dummy), and any sample with `samp_vld` low, produce no output.
- R3: The output data equals the input sample minus that channel's current black level, clamped at zero and never wrapping.
- R4: The black level of each channel is the sum of its accepted black samples divided by the window count, rounded to nearest with exact halves rounded up. Each channel's level depends only on its own samples.
- R5: The window count is 2 × BLACK_POS = 84 samples when `hi_res` is high and BLACK_POS = 42 when it is low.
- R6: The level is updated on a `line_end` cycle only if exactly the window count of black samples was accepted since the previous `line_end`. Otherwise the previous level is kept. A new level applies to samples from the cycle after `line_end`.
- R7: Black-tagged samples that arrive after the window count has been reached in a line are ignored.
- R8: Each line produces exactly one output per active input sample: 5340 per channel in half-resolution mode and 10680 in high-resolution mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_res | input | 1 | 1: interleaved main/sub samples, 0: one sample per position |
| samp_vld | input | 1 | A sample is present this cycle |
| samp_tag | input | 2 | Region tag: 00 idle, 01 black, 10 active, 11 dummy |
| line_end | input | 1 | One-cycle end-of-line strobe |
| in_r | input | DATA_W | Red sample |
| in_g | input | DATA_W | Green sample |
| in_b | input | DATA_W | Blue sample |
| out_vld | output | 1 | Corrected sample present |
| out_r | output | DATA_W | Corrected red |
| out_g | output | DATA_W | Corrected green |
| out_b | output | DATA_W | Corrected blue |

## Verification
The properties assume three things about the inputs:
- A `line_end` strobe never coincides with a valid sample.
- `hi_res` is constant from one `line_end` to the next.
- Tags change only with the sample they describe.

The stimulus follows these rules. It issues each end-of-line strobe on an idle cycle with `samp_vld` low. It changes the mode only on the first cycle of a new line. It mixes idle, dummy and invalid-but-active-tagged cycles into every line.

// File: rtl/obc_pkg.sv
package obc_pkg;

    localparam int NCH = 3;

    typedef enum logic [1:0] {
        TAG_IDLE   = 2'b00,
        TAG_BLACK  = 2'b01,
        TAG_ACTIVE = 2'b10,
        TAG_DUMMY  = 2'b11
    } obc_tag_e;

    typedef struct packed {
        logic take;    // black sample accepted into the sums
        logic act;     // active sample, goes to output
        logic commit;  // line closes with a full window
    } obc_ctl_t;

    // Reciprocal of n scaled by 2^sh, rounded up so that truncation error
    // stays positive and below one count step.
    function automatic longint unsigned ceil_recip(input int unsigned n,
                                                   input int unsigned sh);
        return ((64'd1 << sh) + 64'(n) - 64'd1) / 64'(n);
    endfunction

endpackage

// File: rtl/obc_accum.sv
module obc_accum #(
    parameter int DATA_W = 12,
    parameter int SUM_W  = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add,
    input  logic [DATA_W-1:0] din,
    output logic [SUM_W-1:0]  sum
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + SUM_W'(din);
        end
    end

endmodule

// File: rtl/obc_divide.sv
module obc_divide
    import obc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SUM_W  = 19,
    parameter int N_LO   = 42,
    parameter int N_HI   = 84,
    parameter int SHIFT  = 26
) (
    input  logic              hi,
    input  logic [SUM_W-1:0]  sum,
    output logic [DATA_W-1:0] avg
);

    localparam int RW = SHIFT + 1;
    localparam int PW = SUM_W + RW;
    localparam logic [RW-1:0] RECIP_LO = RW'(ceil_recip(N_LO, SHIFT));
    localparam logic [RW-1:0] RECIP_HI = RW'(ceil_recip(N_HI, SHIFT));

    logic [RW-1:0] recip;
    logic [PW-1:0] prod;
    logic [PW-1:0] rnd;

    always_comb begin
        recip = hi ? RECIP_HI : RECIP_LO;
        prod  = PW'(sum) * PW'(recip);
        rnd   = prod + (PW'(1) << (SHIFT - 1));
    end

    assign avg = DATA_W'(rnd >> SHIFT);

endmodule

// File: rtl/obc_sat_sub.sv
module obc_sat_sub #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    assign y = (a > b) ? (a - b) : '0;

endmodule

// File: rtl/obc_black_clamp.sv
module obc_black_clamp
    import obc_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int BLACK_POS = 42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_res,
    input  logic              samp_vld,
    input  logic [1:0]        samp_tag,
    input  logic              line_end,
    input  logic [DATA_W-1:0] in_r,
    input  logic [DATA_W-1:0] in_g,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_r,
    output logic [DATA_W-1:0] out_g,
    output logic [DATA_W-1:0] out_b
);

    localparam int NEED_HI = 2 * BLACK_POS;
    localparam int CNT_W   = $clog2(NEED_HI + 1);
    localparam int SUM_W   = DATA_W + CNT_W;
    localparam int SHIFT   = SUM_W + CNT_W;

    obc_tag_e                      tag;
    obc_ctl_t                      ctl;
    logic [CNT_W-1:0]              need;
    logic [CNT_W-1:0]              blk_cnt;
    logic [NCH-1:0][DATA_W-1:0]    din;
    logic [NCH-1:0][DATA_W-1:0]    lvl_all;
    logic [NCH-1:0][DATA_W-1:0]    out_all;

    assign tag  = obc_tag_e'(samp_tag);
    assign din  = {in_b, in_g, in_r};
    assign need = hi_res ? CNT_W'(NEED_HI) : CNT_W'(BLACK_POS);

    always_comb begin
        ctl.take   = samp_vld && (tag == TAG_BLACK) && (blk_cnt < need) && !line_end;
        ctl.act    = samp_vld && (tag == TAG_ACTIVE);
        ctl.commit = line_end && (blk_cnt == need);
    end

    // Black samples accepted in the current line
    always_ff @(posedge clk) begin
        if (rst || line_end) begin
            blk_cnt <= '0;
        end else if (ctl.take) begin
            blk_cnt <= blk_cnt + 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] avg;
        logic [DATA_W-1:0] lvl_q;
        logic [DATA_W-1:0] diff;
        logic [DATA_W-1:0] out_q;

        obc_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_acc (
            .clk   (clk),
            .rst   (rst),
            .clear (line_end),
            .add   (ctl.take),
            .din   (din[c]),
            .sum   (sum)
        );

        obc_divide #(
            .DATA_W (DATA_W),
            .SUM_W  (SUM_W),
            .N_LO   (BLACK_POS),
            .N_HI   (NEED_HI),
            .SHIFT  (SHIFT)
        ) u_div (
            .hi  (hi_res),
            .sum (sum),
            .avg (avg)
        );

        obc_sat_sub #(.W(DATA_W)) u_sub (
            .a (din[c]),
            .b (lvl_q),
            .y (diff)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q <= '0;
            end else if (ctl.commit) begin
                lvl_q <= avg;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '0;
            end else if (ctl.act) begin
                out_q <= diff;
            end
        end

        assign lvl_all[c] = lvl_q;
        assign out_all[c] = out_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= ctl.act;
        end
    end

    assign out_r = out_all[0];
    assign out_g = out_all[1];
    assign out_b = out_all[2];

endmodule

// File: rtl/obc_black_clamp_chk.sv
module obc_black_clamp_chk
    import obc_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int BLACK_POS = 42
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   samp_vld,
    input logic [1:0]             samp_tag,
    input logic                   line_end,
    input logic [DATA_W-1:0]      in_r,
    input logic [DATA_W-1:0]      in_g,
    input logic [DATA_W-1:0]      in_b,
    input logic                   out_vld,
    input logic [DATA_W-1:0]      out_r,
    input logic [DATA_W-1:0]      out_g,
    input logic [DATA_W-1:0]      out_b,
    input logic [$clog2(2*BLACK_POS+1)-1:0] blk_cnt,
    input logic [NCH-1:0][DATA_W-1:0] lvl_all
);

    localparam int NEED_HI = 2 * BLACK_POS;

    logic act_in;
    assign act_in = samp_vld && (samp_tag == 2'b10);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_vld && lvl_all == '0));

    a_r2_active_emits: assert property (@(posedge clk) disable iff (rst)
        act_in |=> out_vld);

    a_r2_other_dropped: assert property (@(posedge clk) disable iff (rst)
        !act_in |=> !out_vld);

    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_r <= $past(in_r) && out_g <= $past(in_g) && out_b <= $past(in_b)));

    a_r1_zero_level_passes: assert property (@(posedge clk) disable iff (rst)
        (act_in && lvl_all == '0) |=>
            (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));

    a_r6_level_only_at_line_end: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(lvl_all));

    a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
        blk_cnt <= ($clog2(2*BLACK_POS+1))'(NEED_HI));

endmodule

bind obc_black_clamp obc_black_clamp_chk #(
    .DATA_W    (DATA_W),
    .BLACK_POS (BLACK_POS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .samp_vld (samp_vld),
    .samp_tag (samp_tag),
    .line_end (line_end),
    .in_r     (in_r),
    .in_g     (in_g),
    .in_b     (in_b),
    .out_vld  (out_vld),
    .out_r    (out_r),
    .out_g    (out_g),
    .out_b    (out_b),
    .blk_cnt  (blk_cnt),
    .lvl_all  (lvl_all)
);

// File: tb/obc_black_clamp_tb.sv
module obc_black_clamp_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 12;
    localparam int BLACK_POS  = 42;
    localparam int EFF_PIX    = 5340;
    localparam int WD_CYCLES  = 200000;
    localparam int NROWS      = 7;

    typedef struct packed {
        logic        hi;
        logic        pat;     // 0: k%3!=0 gets delta, 1: odd k gets delta
        logic [7:0]  nb;      // black samples sent
        logic [11:0] b0, b1, b2;
        logic [3:0]  delta;
        logic [11:0] e0, e1, e2;  // level after this line (hand-derived)
        logic [13:0] npos;
    } row_t;

    // Each row: one line. Its pixels are corrected with the previous row's level.
    localparam row_t ROWS [NROWS] = '{
        '{1'b1, 1'b0, 8'd84, 12'd100,  12'd200, 12'd300,  4'd3, 12'd102,  12'd202, 12'd302,  14'd5340},
        '{1'b0, 1'b0, 8'd42, 12'd4000, 12'd50,  12'd0,    4'd1, 12'd4001, 12'd51,  12'd1,    14'd5340},
        '{1'b1, 1'b0, 8'd90, 12'd10,   12'd20,  12'd30,   4'd2, 12'd11,   12'd21,  12'd31,   14'd5340},
        '{1'b0, 1'b0, 8'd30, 12'd500,  12'd500, 12'd500,  4'd0, 12'd11,   12'd21,  12'd31,   14'd5340},
        '{1'b0, 1'b0, 8'd42, 12'd7,    12'd0,   12'd4094, 4'd1, 12'd8,    12'd1,   12'd4095, 14'd5340},
        '{1'b1, 1'b1, 8'd84, 12'd0,    12'd0,   12'd0,    4'd1, 12'd1,    12'd1,   12'd1,    14'd5340},
        '{1'b0, 1'b0, 8'd0,  12'd0,    12'd0,   12'd0,    4'd0, 12'd1,    12'd1,   12'd1,    14'd40}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              hi_res;
    logic              samp_vld;
    logic [1:0]        samp_tag;
    logic              line_end;
    logic [DATA_W-1:0] in_r, in_g, in_b;
    logic              out_vld;
    logic [DATA_W-1:0] out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;
    int cur_lvl [3];
    bit cur_hi;
    bit exp_vld;
    int exp_d [3];
    int mism, first_act, first_exp, out_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    obc_black_clamp #(.DATA_W(DATA_W), .BLACK_POS(BLACK_POS)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .hi_res   (hi_res),
        .samp_vld (samp_vld),
        .samp_tag (samp_tag),
        .line_end (line_end),
        .in_r     (in_r),
        .in_g     (in_g),
        .in_b     (in_b),
        .out_vld  (out_vld),
        .out_r    (out_r),
        .out_g    (out_g),
        .out_b    (out_b)
    );

    function automatic int clampsub(int a, int b);
        return (a > b) ? a - b : 0;
    endfunction

    function automatic string row_req(int i);
        case (i)
            0: return "R1 R2";
            1: return "R3 R4 R5";
            2: return "R3 R5";
            3: return "R4 R7";
            4: return "R6";
            5: return "R4";
            default: return "R4 R2";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic compare();
        int a [3];
        a[0] = int'(out_r); a[1] = int'(out_g); a[2] = int'(out_b);
        if (out_vld) out_cnt++;
        if (out_vld !== exp_vld) begin
            mism++;
            if (mism == 1) begin first_act = int'(out_vld); first_exp = int'(exp_vld); end
        end else if (exp_vld) begin
            for (int c = 0; c < 3; c++) begin
                if (a[c] != exp_d[c]) begin
                    mism++;
                    if (mism == 1) begin first_act = a[c]; first_exp = exp_d[c]; end
                end
            end
        end
    endtask

    task automatic drive(input bit v, input logic [1:0] t, input bit le,
                         input int r, input int g, input int b);
        @(negedge clk);
        compare();
        hi_res   = cur_hi;
        samp_vld = v;
        samp_tag = t;
        line_end = le;
        in_r = DATA_W'(r); in_g = DATA_W'(g); in_b = DATA_W'(b);
        exp_vld  = v && (t == 2'b10);
        exp_d[0] = clampsub(r, cur_lvl[0]);
        exp_d[1] = clampsub(g, cur_lvl[1]);
        exp_d[2] = clampsub(b, cur_lvl[2]);
    endtask

    task automatic run_line(input row_t rw, input int ridx, input string req);
        int need, nsamp, base [3], bv [3];
        mism = 0; out_cnt = 0; first_act = 0; first_exp = 0;
        cur_hi = rw.hi;
        need = rw.hi ? 2 * BLACK_POS : BLACK_POS;
        base[0] = int'(rw.b0); base[1] = int'(rw.b1); base[2] = int'(rw.b2);
        drive(1'b1, 2'b11, 1'b0, 77, 88, 99);
        drive(1'b1, 2'b00, 1'b0, 11, 22, 33);
        drive(1'b0, 2'b10, 1'b0, 999, 999, 999);
        for (int k = 0; k < int'(rw.nb); k++) begin
            for (int c = 0; c < 3; c++) begin
                if (k >= need) bv[c] = 4095;
                else if (rw.pat) bv[c] = base[c] + ((k % 2) * int'(rw.delta));
                else bv[c] = base[c] + (((k % 3) != 0) ? int'(rw.delta) : 0);
            end
            drive(1'b1, 2'b01, 1'b0, bv[0], bv[1], bv[2]);
        end
        for (int k = 0; k < 3; k++) drive(1'b1, 2'b11, 1'b0, 5, 6, 7);
        nsamp = int'(rw.npos) * (rw.hi ? 2 : 1);
        for (int j = 0; j < nsamp; j++) begin
            drive(1'b1, 2'b10, 1'b0,
                  (j * 37 + ridx * 13) % 4096,
                  (j * 37 + 1000 + ridx * 13) % 4096,
                  (j * 37 + 2000 + ridx * 13) % 4096);
        end
        drive(1'b1, 2'b11, 1'b0, 1, 2, 3);
        drive(1'b1, 2'b01, 1'b0, 4095, 4095, 4095);  // after window closed or extra
        drive(1'b0, 2'b00, 1'b1, 0, 0, 0);
        cur_lvl[0] = int'(rw.e0); cur_lvl[1] = int'(rw.e1); cur_lvl[2] = int'(rw.e2);
        drive(1'b0, 2'b00, 1'b0, 0, 0, 0);
        drive(1'b0, 2'b00, 1'b0, 0, 0, 0);
        check(mism == 0, req, $sformatf("pixels row %0d", ridx), first_act, first_exp);
        check(out_cnt == nsamp, "R8", $sformatf("output count row %0d", ridx), out_cnt, nsamp);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        row_t z;
        rst = 1'b1; hi_res = 1'b0; samp_vld = 1'b0; samp_tag = 2'b00; line_end = 1'b0;
        in_r = '0; in_g = '0; in_b = '0;
        cur_hi = 1'b0; exp_vld = 1'b0;
        for (int c = 0; c < 3; c++) begin cur_lvl[c] = 0; exp_d[c] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_vld == 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
        check(out_r == 0 && out_g == 0 && out_b == 0, "R1", "data in reset",
              int'(out_r) + int'(out_g) + int'(out_b), 0);
        rst = 1'b0;

        // Table-driven lines
        for (int i = 0; i < NROWS; i++) begin
            run_line(ROWS[i], i, row_req(i));
        end

        // Reset in mid-run clears the level held from the last row
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_vld == 1'b0, "R1", "out_vld after mid-run reset", int'(out_vld), 0);
        rst = 1'b0;
        for (int c = 0; c < 3; c++) cur_lvl[c] = 0;
        exp_vld = 1'b0;
        z = '{1'b0, 1'b0, 8'd0, 12'd0, 12'd0, 12'd0, 4'd0, 12'd0, 12'd0, 12'd0, 14'd64};
        run_line(z, 7, "R1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule